// File: doc/BRIEF.md
# Workspace Operand Address Generator

This block resolves the effective memory address of one instruction operand for a processor that keeps its general registers in ordinary memory, at a base held in a workspace pointer. A decoder hands it a register number, a two-bit addressing-mode field, an operand-size flag, the workspace pointer and the current program counter. The block then performs whatever memory traffic the mode needs: reading a register word, fetching an extension word that follows the instruction, and writing back a stepped register for auto-increment. It returns the effective address, the program counter after any extension fetch, and an estimate of the clock cycles the access costs.

The cycle estimate depends on the addressing mode, the operand size and on which 8 KiB region of the address space each charged access falls in. Some regions are fast and cost nothing extra. Others carry a fixed penalty for each access charged to them.

The block talks to memory over a single valid/ready port. A transfer completes in the cycle where both valid and ready are high. Read data is taken in that same cycle. One decode runs at a time. The block reports busy from acceptance until its one-cycle done pulse, and it accepts the next request only after that pulse.

Top module: `wsop_addr_gen`

## Requirements
- R1: The register's memory address is the workspace pointer with bit 0 cleared, plus twice the register number, modulo 2^16. Every register read or write-back goes to this address.
- R2: Mode 0 (direct register) returns the register's memory address as the effective address, with a cost of 0 and the program counter unchanged. It makes no memory access.
- R3: Mode 1 (indirect) reads the register word and returns it as the effective address, with a cost of 4 plus one penalty for the register's address. The program counter is unchanged.
- R4: Mode 2 (indexed) with a nonzero register fetches the extension word at the program counter and returns program counter + 2. The effective address is the register contents plus the extension word, modulo 2^16. The cost is 8 plus two penalties for the register's address, plus 2 more when the byte flag is set.
- R5: Mode 2 with register 0 is absolute addressing. The extension word is the effective address and no register is read. The cost is 8 plus one penalty for the extension word's value, plus 2 more when the byte flag is set. The returned program counter is program counter + 2.
- R6: Mode 3 (auto-increment) returns the register contents as the effective address. It writes the register back as contents + 2 for word operands, or contents + 1 for byte operands (byte flag = 1), modulo 2^16. The cost is 8 for word operands or 6 for byte operands, plus two penalties for the register's address. The program counter is unchanged.
- R7: The penalty of an address is selected by its bits 15:13. Regions 0 and 4 cost 0, region 3 costs 2, and regions 1, 2, 5, 6 and 7 cost 4.
- R8: Any write-back completes before done is asserted, so the next decode sees the updated register. Done is a single-cycle pulse, and the effective address, program counter and cost are valid in that cycle.
- R9: Busy is high from the cycle after acceptance through the done cycle, and req_ready is its inverse. While a memory request waits for ready, its valid, address and write flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Decode request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_reg | input | 4 | Register number |
| req_mode | input | 2 | Addressing mode (0 direct, 1 indirect, 2 indexed/absolute, 3 auto-increment) |
| req_byte | input | 1 | 1 = byte operand, 0 = word operand |
| req_wp | input | 16 | Workspace pointer |
| req_pc | input | 16 | Program counter pointing at a possible extension word |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| pc_out | output | 16 | Program counter after the decode |
| cycles | output | 8 | Estimated cycle cost |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ready |

## Verification
The hardest case to reach is an auto-increment decode immediately followed by another decode of the same register while memory stalls. The write-back then has to land before done, or the second read returns a stale value. The stimulus runs back-to-back auto-increment decodes on one register, under a pseudo-random ready pattern that holds requests pending for several cycles. Each expected address comes from the bench's own memory model, which already contains the earlier write. Byte auto-increment at 0xFFFF and workspace pointers near the top of memory exercise the 16-bit wrap. Preloaded extension words land in each address region, so every penalty value is charged.

// File: rtl/wsop_pkg.sv
package wsop_pkg;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_INDEXED  = 2'd2,
    AM_AUTOINC  = 2'd3
  } am_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EXT  = 3'd1,
    ST_RREG = 3'd2,
    ST_WREG = 3'd3,
    ST_DONE = 3'd4
  } ag_state_e;

endpackage

// File: rtl/wsop_region_pen.sv
module wsop_region_pen #(
  parameter int ADDR_W      = 16,
  parameter int REGION_BITS = 3,
  parameter int PEN_W       = 4,
  parameter logic [PEN_W*(2**REGION_BITS)-1:0] PEN_TABLE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PEN_W-1:0]  pen
);
  logic [REGION_BITS-1:0] region;

  assign region = addr[ADDR_W-1 -: REGION_BITS];

  always_comb begin
    pen = '0;
    for (int i = 0; i < 2**REGION_BITS; i++) begin
      if (region == REGION_BITS'(i)) pen = PEN_TABLE[i*PEN_W +: PEN_W];
    end
  end
endmodule

// File: rtl/wsop_cost_calc.sv
module wsop_cost_calc import wsop_pkg::*; #(
  parameter int PEN_W          = 4,
  parameter int CYC_W          = 8,
  parameter int IND_BASE       = 4,
  parameter int IDX_BASE       = 8,
  parameter int AUTO_W_BASE    = 8,
  parameter int AUTO_B_BASE    = 6,
  parameter int BYTE_IDX_EXTRA = 2
) (
  input  am_mode_e          mode,
  input  logic              is_byte,
  input  logic              reg_zero,
  input  logic [PEN_W-1:0]  pen_reg,
  input  logic [PEN_W-1:0]  pen_ext,
  output logic [CYC_W-1:0]  cost
);
  logic [CYC_W-1:0] pr, pe, extra;

  assign pr    = CYC_W'(pen_reg);
  assign pe    = CYC_W'(pen_ext);
  assign extra = is_byte ? CYC_W'(BYTE_IDX_EXTRA) : '0;

  always_comb begin
    unique case (mode)
      AM_DIRECT:   cost = '0;
      AM_INDIRECT: cost = CYC_W'(IND_BASE) + pr;
      AM_INDEXED:  cost = reg_zero ? (CYC_W'(IDX_BASE) + pe + extra)
                                   : (CYC_W'(IDX_BASE) + pr + pr + extra);
      default:     cost = (is_byte ? CYC_W'(AUTO_B_BASE) : CYC_W'(AUTO_W_BASE)) + pr + pr;
    endcase
  end
endmodule

// File: rtl/wsop_addr_gen.sv
module wsop_addr_gen import wsop_pkg::*; #(
  parameter int ADDR_W         = 16,
  parameter int REG_W          = 4,
  parameter int CYC_W          = 8,
  parameter int REGION_BITS    = 3,
  parameter int PEN_W          = 4,
  parameter logic [PEN_W*(2**REGION_BITS)-1:0] PEN_TABLE =
    {4'd4, 4'd4, 4'd4, 4'd0, 4'd2, 4'd4, 4'd4, 4'd0},
  parameter int IND_BASE       = 4,
  parameter int IDX_BASE       = 8,
  parameter int AUTO_W_BASE    = 8,
  parameter int AUTO_B_BASE    = 6,
  parameter int BYTE_IDX_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [1:0]        req_mode,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_wp,
  input  logic [ADDR_W-1:0] req_pc,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] pc_out,
  output logic [CYC_W-1:0]  cycles,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] mem_rdata
);
  localparam int WORD_BYTES = 2;
  localparam int MAX_CYC    = IDX_BASE + BYTE_IDX_EXTRA + 2 * (2**PEN_W - 1);

  // register word address: even workspace base plus two bytes per register
  function automatic logic [ADDR_W-1:0] reg_word_addr(input logic [ADDR_W-1:0] wp,
                                                      input logic [REG_W-1:0]  r);
    logic [ADDR_W-1:0] base;
    base = {wp[ADDR_W-1:1], 1'b0};
    return base + (ADDR_W'(r) << 1);
  endfunction

  // auto-increment step: one for byte operands, a full word otherwise
  function automatic logic [ADDR_W-1:0] step_reg(input logic [ADDR_W-1:0] v,
                                                 input logic              b);
    return v + (b ? ADDR_W'(1) : ADDR_W'(WORD_BYTES));
  endfunction

  ag_state_e         st_q, st_d;
  am_mode_e          mode_q;
  logic              byte_q, regz_q;
  logic [ADDR_W-1:0] ra_q, pc_q, ext_q, val_q;

  // named internal events for the checker
  logic accept, mem_fire, rd_fire, wr_fire;

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = ~req_ready;
  assign accept    = req_valid && req_ready;
  assign mem_valid = (st_q == ST_EXT) || (st_q == ST_RREG) || (st_q == ST_WREG);
  assign mem_we    = (st_q == ST_WREG);
  assign mem_addr  = (st_q == ST_EXT) ? pc_q : ra_q;
  assign mem_wdata = step_reg(val_q, byte_q);
  assign mem_fire  = mem_valid && mem_ready;
  assign rd_fire   = mem_fire && !mem_we;
  assign wr_fire   = mem_fire && mem_we;
  assign done      = (st_q == ST_DONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        unique case (am_mode_e'(req_mode))
          AM_DIRECT:  st_d = ST_DONE;
          AM_INDEXED: st_d = ST_EXT;
          default:    st_d = ST_RREG;
        endcase
      end
      ST_EXT:  if (mem_fire) st_d = regz_q ? ST_DONE : ST_RREG;
      ST_RREG: if (mem_fire) st_d = (mode_q == AM_AUTOINC) ? ST_WREG : ST_DONE;
      ST_WREG: if (mem_fire) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= AM_DIRECT;
      byte_q <= 1'b0;
      regz_q <= 1'b0;
      ra_q   <= '0;
      pc_q   <= '0;
      ext_q  <= '0;
      val_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        mode_q <= am_mode_e'(req_mode);
        byte_q <= req_byte;
        regz_q <= (req_reg == '0);
        ra_q   <= reg_word_addr(req_wp, req_reg);
        pc_q   <= req_pc;
      end
      if (st_q == ST_EXT && rd_fire)  ext_q <= mem_rdata;
      if (st_q == ST_RREG && rd_fire) val_q <= mem_rdata;
    end
  end

  // result selection from held state
  always_comb begin
    unique case (mode_q)
      AM_DIRECT:  ea = ra_q;
      AM_INDEXED: ea = regz_q ? ext_q : (val_q + ext_q);
      default:    ea = val_q;
    endcase
  end

  assign pc_out = (mode_q == AM_INDEXED) ? (pc_q + ADDR_W'(WORD_BYTES)) : pc_q;

  logic [PEN_W-1:0] pen_reg, pen_ext;

  wsop_region_pen #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .PEN_W(PEN_W), .PEN_TABLE(PEN_TABLE)
  ) u_pen_reg (
    .addr(ra_q), .pen(pen_reg)
  );

  wsop_region_pen #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .PEN_W(PEN_W), .PEN_TABLE(PEN_TABLE)
  ) u_pen_ext (
    .addr(ext_q), .pen(pen_ext)
  );

  wsop_cost_calc #(
    .PEN_W(PEN_W), .CYC_W(CYC_W), .IND_BASE(IND_BASE), .IDX_BASE(IDX_BASE),
    .AUTO_W_BASE(AUTO_W_BASE), .AUTO_B_BASE(AUTO_B_BASE), .BYTE_IDX_EXTRA(BYTE_IDX_EXTRA)
  ) u_cost (
    .mode(mode_q), .is_byte(byte_q), .reg_zero(regz_q),
    .pen_reg(pen_reg), .pen_ext(pen_ext), .cost(cycles)
  );

endmodule

// File: rtl/wsop_addr_gen_chk.sv
module wsop_addr_gen_chk #(
  parameter int ADDR_W  = 16,
  parameter int CYC_W   = 8,
  parameter int MAX_CYC = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CYC_W-1:0]  cycles,
  input logic              wr_fire,
  input logic [1:0]        mode_q
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  assert_mem_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  assert_wb_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_write_only_auto_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mode_q == 2'd3);

  assert_direct_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode_q == 2'd0 |-> !mem_valid);

  assert_cost_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cycles <= CYC_W'(MAX_CYC));
endmodule

bind wsop_addr_gen wsop_addr_gen_chk #(
  .ADDR_W(ADDR_W), .CYC_W(CYC_W), .MAX_CYC(MAX_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .cycles(cycles), .wr_fire(wr_fire), .mode_q(mode_q)
);

// File: tb/wsop_addr_gen_test.sv
module wsop_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_reg = '0;
  logic [1:0]  req_mode = '0;
  logic        req_byte = 1'b0;
  logic [15:0] req_wp = '0, req_pc = '0;
  logic        busy, done;
  logic [15:0] ea, pc_out;
  logic [7:0]  cycles;
  logic        mem_valid, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;

  wsop_addr_gen uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, seen = 0, cyc_cnt = 0;
  logic [15:0] store [int];
  logic [15:0] lfsr = 16'hACE1;
  bit stall_on = 1'b0;
  bit wr_seen = 1'b0;
  logic [15:0] wr_a, wr_d;

  typedef struct {
    logic [15:0] ea, pc; logic [7:0] cyc;
    bit wr; logic [15:0] wa, wd; string tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [15:0] model_rd(input logic [15:0] a);
    if (store.exists(int'(a))) return store[int'(a)];
    return {a[7:0], a[15:8]} ^ 16'hC35A;
  endfunction

  // region penalty restated by region groups
  function automatic int pen(input logic [15:0] a);
    case (a[15:13])
      3'd0, 3'd4: return 0;
      3'd3:       return 2;
      default:    return 4;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: data and ready change away from the active edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall_on ? (lfsr[0] & lfsr[5]) : 1'b1;
    mem_rdata = model_rd(mem_addr);
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready && mem_we) begin
      store[int'(mem_addr)] = mem_wdata;
      wr_seen = 1'b1; wr_a = mem_addr; wr_d = mem_wdata;
    end
  end

  // monitor: pops scoreboard on each done
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (sb.size() == 0) begin
        check(0, "R8", "unexpected done", 16'h0, 16'h0);
      end else begin
        e = sb.pop_front();
        check(ea == e.ea, e.tag, "ea", ea, e.ea);
        check(pc_out == e.pc, e.tag, "pc_out", pc_out, e.pc);
        check(cycles == e.cyc, {e.tag, "/R7"}, "cycles", 16'(cycles), 16'(e.cyc));
        if (e.wr) begin
          check(wr_seen, "R8", "write-back before done", 16'(wr_seen), 16'h1);
          check(wr_a == e.wa, "R6", "write-back addr", wr_a, e.wa);
          check(wr_d == e.wd, "R6", "write-back data", wr_d, e.wd);
        end else begin
          check(!wr_seen, "R6", "no write outside auto-increment", 16'(wr_seen), 16'h0);
        end
      end
      seen++;
    end
  end

  task automatic issue(input logic [15:0] wp, input logic [3:0] r, input logic [1:0] m,
                       input bit b, input logic [15:0] pc, input string tag);
    exp_t e;
    logic [15:0] ra, rv, ext;
    int n, c;
    while (!req_ready) @(negedge clk);
    ra  = {wp[15:1], 1'b0} + {11'd0, r, 1'b0};
    rv  = model_rd(ra);
    ext = model_rd(pc);
    e.wr = 0; e.wa = '0; e.wd = '0; e.pc = pc; e.tag = tag;
    case (m)
      2'd0: begin e.ea = ra; c = 0; end
      2'd1: begin e.ea = rv; c = 4 + pen(ra); end
      2'd2: begin
        e.pc = pc + 16'd2;
        if (r == 0) begin e.ea = ext; c = 8 + pen(ext); end
        else begin e.ea = rv + ext; c = 8 + 2 * pen(ra); end
        if (b) c += 2;
      end
      default: begin
        e.ea = rv; e.wr = 1; e.wa = ra;
        e.wd = b ? rv + 16'd1 : rv + 16'd2;
        c = (b ? 6 : 8) + 2 * pen(ra);
      end
    endcase
    e.cyc = 8'(c);
    sb.push_back(e);
    wr_seen = 1'b0;
    n = seen;
    req_valid = 1'b1; req_wp = wp; req_reg = r; req_mode = m; req_byte = b; req_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R9", "busy after accept", {14'd0, busy, req_ready}, 16'h2);
    while (seen == n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      checks++; fails++;
      $display("FAIL R8 watchdog expired actual=%0d expected=<150000", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_valid && req_ready, "R9", "reset state",
          {12'd0, busy, done, mem_valid, req_ready}, 16'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: direct, odd pointer forced even, wrap at the top
    issue(16'h83E1, 4'd15, 2'd0, 0, 16'h6000, "R1_R2 odd wp");
    issue(16'hFFF0, 4'd15, 2'd0, 0, 16'h0100, "R1 wrap");
    // R3: indirect in regions with different penalties
    issue(16'h8300, 4'd3, 2'd1, 0, 16'h0200, "R3 region4");
    issue(16'h2000, 4'd3, 2'd1, 0, 16'h0200, "R3 region1");
    issue(16'h6000, 4'd1, 2'd1, 1, 16'h0200, "R3 region3");
    // R4: indexed with sum wrap
    store[int'(16'h8304)] = 16'hFFF0;
    store[int'(16'h0400)] = 16'h0020;
    issue(16'h8300, 4'd2, 2'd2, 0, 16'h0400, "R4 wrap word");
    issue(16'hA000, 4'd2, 2'd2, 1, 16'h0400, "R4 byte");
    // R5: absolute, penalty from the extension value in each region
    for (int g = 0; g < 8; g++) begin
      store[int'(16'h0600)] = {g[2:0], 13'h0123};
      issue(16'h8300, 4'd0, 2'd2, g[0], 16'h0600, "R5 R7 absolute");
    end
    // R6/R8: back-to-back auto-increment under stalls, byte wrap
    stall_on = 1'b1;
    store[int'(16'h8310)] = 16'hFFFE;
    issue(16'h8300, 4'd8, 2'd3, 1, 16'h0000, "R6 byte");
    issue(16'h8300, 4'd8, 2'd3, 1, 16'h0000, "R6_R8 byte wrap");
    issue(16'h8300, 4'd8, 2'd3, 0, 16'h0000, "R6_R8 word");
    issue(16'h8300, 4'd8, 2'd1, 0, 16'h0000, "R8 sees update");
    issue(16'h6000, 4'd4, 2'd3, 0, 16'h0000, "R6 region3");
    // mixed random traffic
    for (int k = 0; k < 120; k++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      stall_on = rnd[31];
      issue(16'($urandom), rnd[3:0], rnd[5:4], rnd[6], 16'($urandom), "R2_R3_R4_R5_R6 random");
    end
    stall_on = 1'b0;
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R8", "scoreboard drained", 16'(sb.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule